// File: doc/BRIEF.md
# Binary and Even-Ratio Clock Divider

This block derives slower timing signals from one fast clock in two ways at once. A binary ripple-style counter built from toggle stages exposes every bit as a tap. Tap k completes one period every 2^(k+1) input cycles at 50% duty. A separate modulo-m counter raises a one-cycle wrap strobe every m input cycles. That strobe drives a toggle flip-flop, whose output runs at the input frequency divided by 2m, again at 50% duty. m is any value the ratio input can carry.

All outputs are registered and change only on the rising clock edge. They suit use as clock enables or as divided timing references. The ratio is a runtime input. A new value is picked up only when the modulo counter wraps, so the current half-period always finishes at its old length. Reset is synchronous and active high.

Top module: `even_clock_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `taps` becomes 0 and `divOut` becomes 0, and the value on `ratio` at that edge becomes the active division factor.
- R2: Out of reset, `taps` increases by exactly one on every rising edge, so bit k of `taps` has a period of 2^(k+1) cycles and a high time of 2^k cycles.
- R3: `taps` wraps from all ones to all zeros and keeps counting.
- R4: With active factor m, `divOut` first rises m edges after reset is released and then toggles every m edges, giving a period of 2m cycles with m cycles high.
- R5: A factor of m = 1 makes `divOut` toggle on every edge, which is half the input frequency.
- R6: A `ratio` value of 0 is treated as 1.
- R7: A change on `ratio` has no effect until the next wrap of the modulo counter. The half-period in progress keeps the old length, and the new factor governs every half-period after that wrap.
- R8: `divOut` holds its value on every edge that is not a wrap edge and inverts on every wrap edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | RATIO_WIDTH | Requested half-period m in input cycles (0 acts as 1) |
| taps | output | TAP_WIDTH | Binary counter bits; bit k runs at f/2^(k+1) |
| divOut | output | 1 | Toggle output at f/(2m), 50% duty |

## Verification
The bench sweeps several factors, including 1, the largest value, an odd value and 0. For each one it compares every output sample against the ideal period and high time. A divider that reloads its count one cycle late would stretch each half-period by one cycle. A divider that treats 0 literally would stall or run at the wrong rate. A mid-run change of `ratio` tests the deferred pickup: a design that applied the new value at once would toggle at the wrong edge inside the running half-period. The bench also runs the tap counter past all ones to catch a missing wrap, and applies reset in the middle of a run to show that both counters and the toggle stage clear together.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic clear;   // synchronous clear of all datapath state
    logic toggle;  // modulo counter wrapped: invert the toggle stage
  } divStrobes_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RATIO_WIDTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RATIO_WIDTH-1:0] ratio,
  output divStrobes_t            strobes,
  output logic [RATIO_WIDTH-1:0] activeM
);
  localparam logic [RATIO_WIDTH-1:0] ONE = RATIO_WIDTH'(1);

  logic [RATIO_WIDTH-1:0] modCount;
  logic [RATIO_WIDTH-1:0] safeRatio;
  logic                   wrap;

  // A zero request behaves as a factor of one
  always_comb safeRatio = (ratio == '0) ? ONE : ratio;
  always_comb wrap = (modCount == (activeM - ONE));

  // The factor is sampled only at reset or at a wrap, so a change never
  // truncates or stretches the half-period already in progress.
  always_ff @(posedge clk) begin
    if (rst) begin
      modCount <= '0;
      activeM  <= safeRatio;
    end else if (wrap) begin
      modCount <= '0;
      activeM  <= safeRatio;
    end else begin
      modCount <= modCount + ONE;
    end
  end

  always_comb begin
    strobes.clear  = rst;
    strobes.toggle = wrap & ~rst;
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import clkdiv_pkg::*;
#(
  parameter int TAP_WIDTH = 4
) (
  input  logic                 clk,
  input  divStrobes_t          strobes,
  output logic [TAP_WIDTH-1:0] taps,
  output logic                 divOut
);
  // carry[k] is high when every tap below k is one
  logic [TAP_WIDTH:0] carry;
  assign carry[0] = 1'b1;

  // The binary counter is a chain of toggle stages
  for (genvar k = 0; k < TAP_WIDTH; k++) begin : g_tapStage
    assign carry[k+1] = carry[k] & taps[k];
    always_ff @(posedge clk) begin
      if (strobes.clear) taps[k] <= 1'b0;
      else               taps[k] <= taps[k] ^ carry[k];
    end
  end

  // Toggle stage driven by the modulo wrap strobe
  always_ff @(posedge clk) begin
    if (strobes.clear) divOut <= 1'b0;
    else               divOut <= divOut ^ strobes.toggle;
  end
endmodule

// File: rtl/even_clock_divider.sv
module even_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int TAP_WIDTH   = 4,
  parameter int RATIO_WIDTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RATIO_WIDTH-1:0] ratio,
  output logic [TAP_WIDTH-1:0]   taps,
  output logic                   divOut
);
  divStrobes_t            strobes;
  logic [RATIO_WIDTH-1:0] activeM;

  div_ctrl #(.RATIO_WIDTH(RATIO_WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ratio   (ratio),
    .strobes (strobes),
    .activeM (activeM)
  );

  div_datapath #(.TAP_WIDTH(TAP_WIDTH)) u_path (
    .clk     (clk),
    .strobes (strobes),
    .taps    (taps),
    .divOut  (divOut)
  );
endmodule

// File: rtl/even_clock_divider_check.sv
module even_clock_divider_check #(
  parameter int TAP_WIDTH   = 4,
  parameter int RATIO_WIDTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [TAP_WIDTH-1:0]   taps,
  input logic                   divOut,
  input logic                   toggle,
  input logic [RATIO_WIDTH-1:0] activeM
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (taps == '0) && !divOut);

  assert_tap_increment_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (taps == $past(taps) + 1'b1));

  assert_hold_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !toggle |=> $stable(divOut));

  assert_invert_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    toggle |=> (divOut != $past(divOut)));

  assert_factor_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (activeM != '0));

  assert_factor_held_R7: assert property (@(posedge clk) disable iff (rst)
    !toggle |=> $stable(activeM));
endmodule

bind even_clock_divider even_clock_divider_check #(
  .TAP_WIDTH(TAP_WIDTH), .RATIO_WIDTH(RATIO_WIDTH)
) u_check (
  .clk     (clk),
  .rst     (rst),
  .taps    (taps),
  .divOut  (divOut),
  .toggle  (strobes.toggle),
  .activeM (activeM)
);

// File: tb/even_clock_divider_bench.sv
module even_clock_divider_bench;
  localparam int TW = 4;
  localparam int RW = 4;
  localparam int RUN_CYCLES = 64;
  localparam int NVEC = 7;
  // {ratio requested, expected half-period}
  localparam logic [7:0] VEC [NVEC] = '{
    {4'd1, 4'd1}, {4'd2, 4'd2}, {4'd3, 4'd3}, {4'd5, 4'd5},
    {4'd7, 4'd7}, {4'd15, 4'd15}, {4'd0, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] ratio = 4'd3;
  logic [TW-1:0] taps;
  logic          divOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  even_clock_divider #(.TAP_WIDTH(TW), .RATIO_WIDTH(RW)) u_even_clock_divider (
    .clk(clk), .rst(rst), .ratio(ratio), .taps(taps), .divOut(divOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [RW-1:0] r);
    rst = 1'b1;
    ratio = r;
    step();
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    doReset(4'd3);
    chk("R1 taps after reset", int'(taps), 0);
    chk("R1 divOut after reset", int'(divOut), 0);

    // Vector table: R2 R3 R4 R5 R6 period and high-time sweep
    for (int v = 0; v < NVEC; v++) begin
      int half;
      int tapErr;
      int divErr;
      half = int'(VEC[v][3:0]);
      tapErr = 0;
      divErr = 0;
      doReset(VEC[v][7:4]);
      for (int t = 1; t <= RUN_CYCLES; t++) begin
        step();
        if (int'(taps) != (t % 16)) begin
          if (tapErr == 0) chk("R2 R3 taps count", int'(taps), t % 16);
          tapErr++;
        end
        if (int'(divOut) != ((t / half) % 2)) begin
          if (divErr == 0) chk("R4 R5 R6 divOut period", int'(divOut), (t / half) % 2);
          divErr++;
        end
      end
      if (tapErr == 0) chk("R2 R3 taps count", 0, 0);
      if (divErr == 0) chk("R4 R5 R6 divOut period", 0, 0);
    end

    // R7: change from 3 to 5 after edge 4; old factor holds until edge 6
    doReset(4'd3);
    for (int t = 1; t <= 16; t++) begin
      step();
      if (t == 4) ratio = 4'd5;
      if (t == 5)  chk("R7 old half-period kept", int'(divOut), 1);
      if (t == 6)  chk("R7 wrap at old factor", int'(divOut), 0);
      if (t == 10) chk("R7 new factor low span", int'(divOut), 0);
      if (t == 11) chk("R7 new factor toggle", int'(divOut), 1);
      if (t == 15) chk("R7 new factor high span", int'(divOut), 1);
      if (t == 16) chk("R7 second new toggle", int'(divOut), 0);
    end

    // R8: divOut holds between wraps (factor 4: edges 1..3 stay low)
    doReset(4'd4);
    for (int t = 1; t <= 4; t++) begin
      step();
      chk("R8 hold or invert", int'(divOut), (t == 4) ? 1 : 0);
    end

    // R1: reset in mid-run clears everything
    doReset(4'd2);
    for (int t = 1; t <= 7; t++) step();
    doReset(4'd2);
    chk("R1 mid-run taps cleared", int'(taps), 0);
    chk("R1 mid-run divOut cleared", int'(divOut), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule